// File: doc/BRIEF.md
# Register-Access Serial Slave

This block is an I2C target that lets an external controller read and write a 256-entry bank of byte registers. All access goes through one word-address pointer. The pointer is loaded by the first byte after a write-direction device address. It steps by one after every data byte the block stores or sends, in both directions.

The pointer keeps its value across transactions. A read that opens with a fresh START and the read-direction address returns data from wherever the last access left off. A random read loads the pointer in a write-direction phase, turns the bus around with a repeated START, and then reads. Both read entries are accepted.

The block samples SCL and SDA through a two-flop synchronizer. The system clock runs at least eight times faster than SCL. SDA is never driven high: `sda_oe` is a pull-low enable for an external open-drain pad. The serial pins carry no data stream with back-pressure, so the block has no valid/ready interface, and it never stretches SCL.

Top module: `i2c_regbank_slave`

## Requirements
- R1: After reset, `sda_oe` is low, the pointer is 0x00 and every register holds 0x00.
- R2: The first byte after START carries the 7-bit device address in bits 7:1, MSB first, and the direction in bit 0 (1 = read). On a match the block pulls SDA low for the ninth clock (ACK). On a mismatch it gives no ACK and ignores every later bit until the next START or STOP.
- R3: In a write-direction transfer, the byte after the address loads the pointer and is ACKed.
- R4: Each further byte of a write transfer is stored at the pointer and ACKed, and the pointer then steps by one.
- R5: Once the read-direction address is ACKed, the block drives the register at the pointer, MSB first, with no further command, and the pointer steps by one.
- R6: An ACK from the controller after a read byte makes the block send the next register. The run length is unbounded.
- R7: A NACK from the controller after a read byte makes the block release SDA. It drives nothing until the next START or STOP.
- R8: A repeated START right after the word-address ACK, followed by the read address, reads from the newly loaded pointer.
- R9: A read opened by a fresh START with no address phase reads from the retained pointer, including after a STOP.
- R10: The pointer is 8 bits and wraps from 0xFF to 0x00.
- R11: `sda_oe` changes only while the synchronized SCL is low.
- R12: A START seen in any state returns the block to address reception, discarding any partial byte. A STOP returns it to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock as seen on the bus |
| sda_i | input | 1 | Serial data as seen on the bus |
| sda_oe | output | 1 | High pulls SDA low; low releases it |

## Verification
The bench targets the pointer's memory between transactions. A current-address read after a write, after a NACKed read and after an address mismatch shows whether the pointer was kept and stepped correctly. A design that reset it on STOP or skipped a step returns bytes from the wrong register.

A write that crosses 0xFF must land its next byte in 0x00; a pointer wider than 8 bits would write out of range. A START in the middle of a data byte must not store a partial byte. After a NACK the bench clocks eight more bits and expects all ones, so a slave that kept transmitting shows up as stray zeros. A mismatched address must draw no ACK on either byte that follows.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK_ADDR,
    ST_WADDR,
    ST_ACK_WADDR,
    ST_WDATA,
    ST_ACK_WDATA,
    ST_RDATA,
    ST_RACK
  } eng_state_t;
endpackage

// File: rtl/i2cs_line_sync.sv
module i2cs_line_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  // each bus line gets its own flop chain; idle bus level is high
  for (genvar g = 0; g < W; g++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[STAGES-2:0], din[g]};
    end
    assign dout[g] = chain[STAGES-1];
  end
endmodule

// File: rtl/i2cs_bus_events.sv
module i2cs_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  // SDA moving while SCL stays high marks a bus condition
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2cs_regfile.sv
module i2cs_regfile #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[addr] <= wdata;
    end
  end

  assign rdata = mem[addr];
endmodule

// File: rtl/i2cs_engine.sv
module i2cs_engine
  import i2cs_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h3A,
  parameter int         AW       = 8,
  parameter int         DW       = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_s,
  input  logic          sda_s,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_det,
  input  logic          stop_det,
  output logic          sda_oe,
  output logic          rf_we,
  output logic [AW-1:0] rf_addr,
  output logic [DW-1:0] rf_wdata,
  input  logic [DW-1:0] rf_rdata
);
  localparam int             BCW      = $clog2(DW);
  localparam logic [BCW-1:0] LAST_BIT = BCW'(DW - 1);

  eng_state_t     state;
  logic [DW-1:0]  shreg;
  logic [BCW-1:0] bitcnt;
  logic           byte_rdy;
  logic           is_read;
  logic           m_ack;
  logic [AW-1:0]  ptr;
  logic           rd_load;
  logic           wr_en;

  // strobes for the register bank: a byte fetch or a byte store
  always_comb begin
    rd_load = 1'b0;
    wr_en   = 1'b0;
    if (!start_det && !stop_det && scl_fall) begin
      if (state == ST_ACK_ADDR && is_read) rd_load = 1'b1;
      if (state == ST_RACK && m_ack)       rd_load = 1'b1;
      if (state == ST_WDATA && byte_rdy)   wr_en   = 1'b1;
    end
  end

  assign rf_we    = wr_en;
  assign rf_addr  = ptr;
  assign rf_wdata = shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      shreg    <= '0;
      bitcnt   <= '0;
      byte_rdy <= 1'b0;
      is_read  <= 1'b0;
      m_ack    <= 1'b0;
      ptr      <= '0;
      sda_oe   <= 1'b0;
    end else if (start_det) begin
      state    <= ST_ADDR;
      bitcnt   <= '0;
      byte_rdy <= 1'b0;
      sda_oe   <= 1'b0;
    end else if (stop_det) begin
      state    <= ST_IDLE;
      bitcnt   <= '0;
      byte_rdy <= 1'b0;
      sda_oe   <= 1'b0;
    end else begin
      case (state)
        ST_ADDR, ST_WADDR, ST_WDATA: begin
          if (scl_rise && !byte_rdy) begin
            shreg <= {shreg[DW-2:0], sda_s};
            if (bitcnt == LAST_BIT) byte_rdy <= 1'b1;
            else                    bitcnt   <= bitcnt + 1'b1;
          end else if (scl_fall && byte_rdy) begin
            byte_rdy <= 1'b0;
            bitcnt   <= '0;
            case (state)
              ST_ADDR: begin
                if (shreg[DW-1:1] == DEV_ADDR) begin
                  is_read <= shreg[0];
                  sda_oe  <= 1'b1;
                  state   <= ST_ACK_ADDR;
                end else begin
                  state <= ST_IDLE;
                end
              end
              ST_WADDR: begin
                ptr    <= AW'(shreg);
                sda_oe <= 1'b1;
                state  <= ST_ACK_WADDR;
              end
              default: begin
                ptr    <= ptr + 1'b1;
                sda_oe <= 1'b1;
                state  <= ST_ACK_WDATA;
              end
            endcase
          end
        end
        ST_ACK_ADDR: begin
          if (scl_fall) begin
            bitcnt <= '0;
            if (is_read) begin
              shreg  <= rf_rdata;
              sda_oe <= ~rf_rdata[DW-1];
              ptr    <= ptr + 1'b1;
              state  <= ST_RDATA;
            end else begin
              sda_oe <= 1'b0;
              state  <= ST_WADDR;
            end
          end
        end
        ST_ACK_WADDR, ST_ACK_WDATA: begin
          if (scl_fall) begin
            sda_oe <= 1'b0;
            state  <= ST_WDATA;
          end
        end
        ST_RDATA: begin
          if (scl_fall) begin
            if (bitcnt == LAST_BIT) begin
              sda_oe <= 1'b0;
              bitcnt <= '0;
              m_ack  <= 1'b0;
              state  <= ST_RACK;
            end else begin
              bitcnt <= bitcnt + 1'b1;
              shreg  <= {shreg[DW-2:0], 1'b0};
              sda_oe <= ~shreg[DW-2];
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) begin
            m_ack <= ~sda_s;
          end else if (scl_fall) begin
            if (m_ack) begin
              shreg  <= rf_rdata;
              sda_oe <= ~rf_rdata[DW-1];
              ptr    <= ptr + 1'b1;
              state  <= ST_RDATA;
            end else begin
              sda_oe <= 1'b0;
              state  <= ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  // R11: the pull-low enable only moves in the SCL low phase
  a_r11_sda_moves_low: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> !scl_s);

  // R12: a START always lands in address reception
  a_r12_start_to_addr: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (state == ST_ADDR));

  // R12: a STOP always lands in idle
  a_r12_stop_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (state == ST_IDLE));

  // R7: an idle slave never pulls the line
  a_r7_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> !sda_oe);

  // R5 / R10: every byte fetched for transmission steps the pointer, modulo 2^AW
  a_r5_fetch_steps_ptr: assert property (@(posedge clk) disable iff (!rst_n)
    rd_load |=> (ptr == AW'($past(ptr) + 1'b1)));

  // R4: every stored byte steps the pointer
  a_r4_store_steps_ptr: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (ptr == AW'($past(ptr) + 1'b1)));
endmodule

// File: rtl/i2c_regbank_slave.sv
module i2c_regbank_slave #(
  parameter logic [6:0] DEV_ADDR    = 7'h3A,
  parameter int         AW          = 8,
  parameter int         DW          = 8,
  parameter int         SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe
);
  logic [1:0]    sync_out;
  logic          scl_s, sda_s;
  logic          scl_rise, scl_fall, start_det, stop_det;
  logic          rf_we;
  logic [AW-1:0] rf_addr;
  logic [DW-1:0] rf_wdata, rf_rdata;

  i2cs_line_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  ({scl_i, sda_i}),
    .dout (sync_out)
  );
  assign scl_s = sync_out[1];
  assign sda_s = sync_out[0];

  i2cs_bus_events u_events (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_s    (scl_s),
    .sda_s    (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_det(start_det),
    .stop_det (stop_det)
  );

  i2cs_engine #(.DEV_ADDR(DEV_ADDR), .AW(AW), .DW(DW)) u_engine (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_s    (scl_s),
    .sda_s    (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_det(start_det),
    .stop_det (stop_det),
    .sda_oe   (sda_oe),
    .rf_we    (rf_we),
    .rf_addr  (rf_addr),
    .rf_wdata (rf_wdata),
    .rf_rdata (rf_rdata)
  );

  i2cs_regfile #(.AW(AW), .DW(DW)) u_regs (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (rf_we),
    .addr (rf_addr),
    .wdata(rf_wdata),
    .rdata(rf_rdata)
  );
endmodule

// File: tb/i2c_regbank_slave_bench.sv
module i2c_regbank_slave_bench;
  localparam logic [6:0] DEV = 7'h3A;
  localparam int Q = 6;   // quarter-ish spacing in system cycles
  localparam int H = 12;  // SCL high time

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic m_low = 1'b0;
  logic dut_oe;
  logic sda_line;

  int checks = 0;
  int errors = 0;
  int viol = 0;
  logic done = 1'b0;
  logic oe_prev = 1'b0;

  logic [7:0] ref_mem [256];
  logic [7:0] ref_ptr;

  always #2.5 clk = ~clk;

  assign sda_line = ~(dut_oe | m_low);

  i2c_regbank_slave #(.DEV_ADDR(DEV)) u_i2c_regbank_slave (
    .clk   (clk),
    .rst_n (rst_n),
    .scl_i (scl),
    .sda_i (sda_line),
    .sda_oe(dut_oe)
  );

  // R11 monitor: the slave must not move SDA while SCL is high
  always @(posedge clk) begin
    if (rst_n && (dut_oe != oe_prev) && scl) viol++;
    oe_prev <= dut_oe;
  end

  function automatic logic [7:0] rd_addr_byte(input logic rd);
    return {DEV, rd};
  endfunction

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    m_low = ~b;
    wait_cyc(Q); scl = 1'b1;
    wait_cyc(H); scl = 1'b0;
    wait_cyc(Q);
  endtask

  task automatic get_bit(output logic b);
    m_low = 1'b0;
    wait_cyc(Q); scl = 1'b1;
    wait_cyc(H / 2); b = sda_line;
    wait_cyc(H / 2); scl = 1'b0;
    wait_cyc(Q);
  endtask

  task automatic bus_start;
    m_low = 1'b0;
    wait_cyc(Q); scl = 1'b1;
    wait_cyc(H); m_low = 1'b1;
    wait_cyc(H); scl = 1'b0;
    wait_cyc(Q);
  endtask

  task automatic bus_stop;
    m_low = 1'b1;
    wait_cyc(Q); scl = 1'b1;
    wait_cyc(H); m_low = 1'b0;
    wait_cyc(H);
  endtask

  task automatic put_byte(input logic [7:0] b, output logic acked);
    logic a;
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    get_bit(a);
    acked = ~a;
  endtask

  task automatic take_byte(input logic give_ack, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) get_bit(d[i]);
    send_bit(~give_ack);
  endtask

  task automatic do_write(input logic [7:0] addr, input int n);
    logic ak;
    logic [7:0] d;
    bus_start;
    put_byte(rd_addr_byte(1'b0), ak); chk("R2 write address ACK", ak, 1);
    put_byte(addr, ak);               chk("R3 word address ACK", ak, 1);
    ref_ptr = addr;
    for (int i = 0; i < n; i++) begin
      d = 8'($urandom);
      put_byte(d, ak); chk("R4 data ACK", ak, 1);
      ref_mem[ref_ptr] = d;
      ref_ptr = ref_ptr + 8'd1;
    end
    bus_stop;
  endtask

  task automatic read_run(input string req, input int n);
    logic [7:0] d;
    for (int i = 0; i < n; i++) begin
      take_byte(i != n - 1, d);
      chk(req, d, ref_mem[ref_ptr]);
      ref_ptr = ref_ptr + 8'd1;
    end
  endtask

  task automatic do_read_random(input logic [7:0] addr, input int n);
    logic ak;
    bus_start;
    put_byte(rd_addr_byte(1'b0), ak); chk("R2 write address ACK", ak, 1);
    put_byte(addr, ak);               chk("R3 word address ACK", ak, 1);
    ref_ptr = addr;
    bus_start;
    put_byte(rd_addr_byte(1'b1), ak); chk("R8 read address ACK after repeated START", ak, 1);
    read_run("R8 R6 random/sequential read data", n);
    bus_stop;
  endtask

  task automatic do_read_current(input int n);
    logic ak;
    bus_start;
    put_byte(rd_addr_byte(1'b1), ak); chk("R5 read address ACK", ak, 1);
    read_run("R9 R5 current-address read data", n);
    bus_stop;
  endtask

  initial begin
    logic ak;
    logic [7:0] d;
    void'($urandom(32'd1357));
    for (int i = 0; i < 256; i++) ref_mem[i] = 8'h00;
    ref_ptr = 8'h00;

    wait_cyc(5);
    chk("R1 sda_oe during reset", dut_oe, 0);
    rst_n = 1'b1;
    wait_cyc(5);
    chk("R1 sda_oe after reset", dut_oe, 0);

    // R1: pointer starts at 0 and registers are cleared
    do_read_current(3);

    // R3 R4 then R9: a fresh START continues from the retained pointer
    do_write(8'h10, 3);
    do_write(8'h20, 4);
    do_read_current(2);
    do_read_random(8'h10, 3);
    do_read_current(4);

    // R6: long sequential run
    do_write(8'h80, 12);
    do_read_random(8'h80, 20);

    // R2: address mismatch gets no ACK and following bytes are ignored
    bus_start;
    put_byte({DEV ^ 7'h01, 1'b0}, ak); chk("R2 mismatch no ACK", ak, 0);
    put_byte(8'h55, ak);               chk("R2 ignored byte no ACK", ak, 0);
    put_byte(8'hA7, ak);               chk("R2 ignored byte no ACK", ak, 0);
    bus_stop;
    do_read_current(1);  // pointer and registers untouched by the mismatch

    // R7: after NACK the slave lets SDA float for further clocks
    bus_start;
    put_byte(rd_addr_byte(1'b1), ak); chk("R5 read address ACK", ak, 1);
    take_byte(1'b0, d); chk("R5 first byte", d, ref_mem[ref_ptr]);
    ref_ptr = ref_ptr + 8'd1;
    take_byte(1'b0, d); chk("R7 line released after NACK", d, 8'hFF);
    bus_stop;
    chk("R7 sda_oe after stop", dut_oe, 0);

    // R10: writes and reads wrap at the top of the bank
    do_write(8'hFE, 4);
    chk("R10 pointer after wrap write", ref_ptr, 8'h02);
    do_read_random(8'hFD, 6);
    do_read_current(1);

    // R12: START in the middle of a data byte drops the partial byte
    bus_start;
    put_byte(rd_addr_byte(1'b0), ak); chk("R2 write address ACK", ak, 1);
    put_byte(8'h40, ak);              chk("R3 word address ACK", ak, 1);
    ref_ptr = 8'h40;
    for (int i = 0; i < 4; i++) send_bit(1'b0);
    bus_start;
    put_byte(rd_addr_byte(1'b1), ak); chk("R12 address after abort ACK", ak, 1);
    take_byte(1'b0, d); chk("R12 partial byte discarded", d, ref_mem[8'h40]);
    ref_ptr = ref_ptr + 8'd1;
    bus_stop;

    // R12: STOP in the middle of a read address returns to idle, no ACK later
    bus_start;
    for (int i = 0; i < 3; i++) send_bit(1'b0);
    bus_stop;
    do_read_current(2);

    // constrained random mix
    for (int t = 0; t < 30; t++) begin
      int op;
      op = int'($urandom_range(2, 0));
      case (op)
        0: do_write(8'($urandom), int'($urandom_range(5, 1)));
        1: do_read_random(8'($urandom), int'($urandom_range(5, 1)));
        default: do_read_current(int'($urandom_range(4, 1)));
      endcase
    end

    chk("R11 SDA moved while SCL high", viol, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule